// File: doc/BRIEF.md
# Receive Start-of-Frame Checker

This block sits on the receive path of a 40G Ethernet MAC, directly after a 64-bit parallel data/control interface that carries eight byte lanes per clock. Each lane has its own control flag. The block examines the first word of each packet and decides whether to forward the packet or discard it. A packet opens only when lane 0 carries the start control character. When the build-time strict option is set, two run-time control bits can also require an exact preamble, an exact start-frame delimiter, or both.

Accepted packets are forwarded one cycle later, word for word. The opening word is marked with a start-of-packet flag. Forwarding continues up to and including the word that holds a terminate control character. A packet that fails an enabled check is suppressed until its terminate word, and one pulse reports the discard. Idle words, and any word that is not a valid start word while no packet is open, produce no output.

Top module: `rx_sof_check`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_sop` and `drop_pulse` are low.
- R2: With no packet open, a word opens a packet only if lane 0 (bits 7:0) holds 0xFB and its control flag (`rx_ctrl[0]`) is set. A start character with the flag clear, a different lane 0 control code, or 0xFB in any other lane produces no output and no drop pulse.
- R3: An accepted start word appears on `out_data`/`out_ctrl` one cycle after its input cycle, unchanged, with `out_valid` and `out_sop` both high.
- R4: Each word after an accepted start word is forwarded one cycle later with `out_valid` high and `out_sop` low. This continues up to and including the first word that has 0xFD in any lane with that lane's control flag set. After that word the block returns to waiting for a start word.
- R5: With `STRICT_EN` = 0, preamble and delimiter contents are never checked, `cfg_pre_chk` and `cfg_sfd_chk` have no effect, and `drop_pulse` never rises.
- R6: With `STRICT_EN` = 1 and `cfg_pre_chk` high, a start word is accepted only if lanes 1 to 6 each hold 0x55 with their control flags clear.
- R7: With `STRICT_EN` = 1 and `cfg_sfd_chk` high, a start word is accepted only if lane 7 holds 0xD5 with its control flag clear.
- R8: A start word that fails an enabled check raises `drop_pulse` for one cycle, in the cycle its output would have appeared. None of that packet's words, up to and including its terminate word, raises `out_valid`.
- R9: The control bits are taken in the cycle of the start word. Changing them later in the packet changes neither the forwarding nor the dropping of that packet.
- R10: A start word in the cycle right after a terminate word is handled as a new packet, with no idle gap needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pre_chk | input | 1 | Enables the preamble check (strict builds only) |
| cfg_sfd_chk | input | 1 | Enables the delimiter check (strict builds only) |
| rx_data | input | 64 | Received word, lane n in bits 8n+7:8n |
| rx_ctrl | input | 8 | Control flag per lane |
| out_valid | output | 1 | Forwarded word is valid |
| out_sop | output | 1 | Forwarded word opens a packet |
| out_data | output | 64 | Forwarded word |
| out_ctrl | output | 8 | Forwarded control flags |
| drop_pulse | output | 1 | One-cycle pulse per discarded packet |

## Verification
The bench drives near-miss start words: the start character without its control flag, the start character in a lane other than 0, and the wrong control code in lane 0. A design that opened packets too easily would emit data on these words. It corrupts one preamble byte, sets one preamble control flag, or damages the delimiter, under every combination of the two control bits. A design that mixed up the bits would drop good packets or pass bad ones. It flips the control bits in the middle of a packet, which would expose a design that re-checks later words. It also places a terminate in each lane and sends packets back to back, where a missed terminate would leak a dropped packet's tail or swallow the next start word. A non-strict copy receives the same stimulus and must never drop.

// File: rtl/rx_sof_pkg.sv
package rx_sof_pkg;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_DROP = 2'd2
  } sof_state_e;
endpackage

// File: rtl/rx_sof_lane_scan.sv
module rx_sof_lane_scan
  import rx_sof_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [8*LANES-1:0] data,
  input  logic [LANES-1:0]   ctrl,
  output logic               is_start,
  output logic               pre_ok,
  output logic               sfd_ok,
  output logic               has_term
);
  localparam int PRE_LANES = LANES - 2;

  logic [LANES-1:0]     term_vec;
  logic [PRE_LANES-1:0] pre_vec;

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_term
      assign term_vec[i] = ctrl[i] && (data[8*i +: 8] == CH_TERM);
    end
    for (i = 0; i < PRE_LANES; i++) begin : g_pre
      assign pre_vec[i] = !ctrl[i+1] && (data[8*(i+1) +: 8] == PRE_BYTE);
    end
  endgenerate

  assign is_start = ctrl[0] && (data[7:0] == CH_START);
  assign pre_ok   = &pre_vec;
  assign sfd_ok   = !ctrl[LANES-1] && (data[8*(LANES-1) +: 8] == SFD_BYTE);
  assign has_term = |term_vec;
endmodule

// File: rtl/rx_sof_policy.sv
module rx_sof_policy #(
  parameter bit STRICT_EN = 1'b1
) (
  input  logic pre_ok,
  input  logic sfd_ok,
  input  logic en_pre,
  input  logic en_sfd,
  output logic accept
);
  generate
    if (STRICT_EN) begin : g_strict
      assign accept = (pre_ok || !en_pre) && (sfd_ok || !en_sfd);
    end else begin : g_loose
      logic unused_inputs;
      assign unused_inputs = ^{pre_ok, sfd_ok, en_pre, en_sfd};
      assign accept = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rx_sof_check.sv
module rx_sof_check
  import rx_sof_pkg::*;
#(
  parameter int LANES     = 8,
  parameter bit STRICT_EN = 1'b1,
  localparam int DW       = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_pre_chk,
  input  logic             cfg_sfd_chk,
  input  logic [DW-1:0]    rx_data,
  input  logic [LANES-1:0] rx_ctrl,
  output logic             out_valid,
  output logic             out_sop,
  output logic [DW-1:0]    out_data,
  output logic [LANES-1:0] out_ctrl,
  output logic             drop_pulse
);
  sof_state_e state_q, state_d;
  logic is_start, pre_ok, sfd_ok, has_term, accept;
  logic fwd_d, sop_d, drop_d;

  rx_sof_lane_scan #(.LANES(LANES)) u_scan (
    .data     (rx_data),
    .ctrl     (rx_ctrl),
    .is_start (is_start),
    .pre_ok   (pre_ok),
    .sfd_ok   (sfd_ok),
    .has_term (has_term)
  );

  rx_sof_policy #(.STRICT_EN(STRICT_EN)) u_policy (
    .pre_ok (pre_ok),
    .sfd_ok (sfd_ok),
    .en_pre (cfg_pre_chk),
    .en_sfd (cfg_sfd_chk),
    .accept (accept)
  );

  // The decision is made entirely in the start-word cycle, so the control
  // bits only matter there; later words never consult them.
  always_comb begin
    state_d = state_q;
    fwd_d   = 1'b0;
    sop_d   = 1'b0;
    drop_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (is_start) begin
          if (accept) begin
            fwd_d   = 1'b1;
            sop_d   = 1'b1;
            state_d = ST_PASS;
          end else begin
            drop_d  = 1'b1;
            state_d = ST_DROP;
          end
        end
      end
      ST_PASS: begin
        fwd_d = 1'b1;
        if (has_term) state_d = ST_IDLE;
      end
      ST_DROP: begin
        if (has_term) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      out_valid  <= 1'b0;
      out_sop    <= 1'b0;
      drop_pulse <= 1'b0;
      out_data   <= '0;
      out_ctrl   <= '0;
    end else begin
      state_q    <= state_d;
      out_valid  <= fwd_d;
      out_sop    <= sop_d;
      drop_pulse <= drop_d;
      out_data   <= rx_data;
      out_ctrl   <= rx_ctrl;
    end
  end
endmodule

// File: rtl/rx_sof_check_sva.sv
module rx_sof_check_sva
  import rx_sof_pkg::*;
#(
  parameter int LANES     = 8,
  parameter bit STRICT_EN = 1'b1,
  localparam int DW       = 8 * LANES
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_pre_chk,
  input logic             cfg_sfd_chk,
  input logic [DW-1:0]    rx_data,
  input logic [LANES-1:0] rx_ctrl,
  input logic             out_valid,
  input logic             out_sop,
  input logic [DW-1:0]    out_data,
  input logic [LANES-1:0] out_ctrl,
  input logic             drop_pulse
);
  logic in_start, in_pre_good, in_sfd_good;

  always_comb begin
    in_start    = rx_ctrl[0] && (rx_data[7:0] == CH_START);
    in_pre_good = 1'b1;
    for (int k = 1; k < LANES - 1; k++) begin
      if (rx_ctrl[k] || rx_data[8*k +: 8] != PRE_BYTE) in_pre_good = 1'b0;
    end
    in_sfd_good = !rx_ctrl[LANES-1] && (rx_data[8*(LANES-1) +: 8] == SFD_BYTE);
  end

  assert_sop_from_start_R2: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> $past(in_start));

  assert_sop_valid_R3: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);

  assert_word_unchanged_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == $past(rx_data) && out_ctrl == $past(rx_ctrl)));

  assert_loose_no_drop_R5: assert property (@(posedge clk) disable iff (rst)
    !(STRICT_EN == 1'b0 && drop_pulse));

  assert_pre_enforced_R6: assert property (@(posedge clk) disable iff (rst)
    (STRICT_EN == 1'b1 && out_sop && $past(cfg_pre_chk)) |-> $past(in_pre_good));

  assert_sfd_enforced_R7: assert property (@(posedge clk) disable iff (rst)
    (STRICT_EN == 1'b1 && out_sop && $past(cfg_sfd_chk)) |-> $past(in_sfd_good));

  assert_drop_silent_R8: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> !out_valid);

  assert_drop_tail_silent_R8: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |=> !out_valid);

  assert_drop_from_start_R8: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> $past(in_start));
endmodule

bind rx_sof_check rx_sof_check_sva #(.LANES(LANES), .STRICT_EN(STRICT_EN)) u_sva (.*);

// File: tb/tb_rx_sof_check.sv
`timescale 1ns/1ps
module tb_rx_sof_check;
  localparam int LANES = 8;
  localparam int DW    = 8 * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_pre_chk = 1'b0, cfg_sfd_chk = 1'b0;
  logic [DW-1:0]    rx_data = '0;
  logic [LANES-1:0] rx_ctrl = '0;

  logic             o_valid[2], o_sop[2], o_drop[2];
  logic [DW-1:0]    o_data[2];
  logic [LANES-1:0] o_ctrl[2];

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rx_sof_check #(.LANES(LANES), .STRICT_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .cfg_pre_chk(cfg_pre_chk), .cfg_sfd_chk(cfg_sfd_chk),
    .rx_data(rx_data), .rx_ctrl(rx_ctrl), .out_valid(o_valid[0]), .out_sop(o_sop[0]),
    .out_data(o_data[0]), .out_ctrl(o_ctrl[0]), .drop_pulse(o_drop[0]));

  rx_sof_check #(.LANES(LANES), .STRICT_EN(1'b0)) dut_loose (
    .clk(clk), .rst(rst), .cfg_pre_chk(cfg_pre_chk), .cfg_sfd_chk(cfg_sfd_chk),
    .rx_data(rx_data), .rx_ctrl(rx_ctrl), .out_valid(o_valid[1]), .out_sop(o_sop[1]),
    .out_data(o_data[1]), .out_ctrl(o_ctrl[1]), .drop_pulse(o_drop[1]));

  // Behavioural reference: index 0 strict, index 1 non-strict.
  int               m_mode[2];  // 0 waiting, 1 forwarding, 2 discarding
  logic             e_valid[2], e_sop[2], e_drop[2];
  logic [DW-1:0]    e_data[2];
  logic [LANES-1:0] e_ctrl[2];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      bit start, good, term;
      if (rst) begin
        m_mode[k] = 0;
        e_valid[k] <= 1'b0; e_sop[k] <= 1'b0; e_drop[k] <= 1'b0;
      end else begin
        start = rx_ctrl[0] && rx_data[7:0] == 8'hFB;
        good = 1'b1;
        if (k == 0 && cfg_pre_chk)
          for (int b = 1; b <= 6; b++)
            if (rx_ctrl[b] || rx_data[8*b +: 8] != 8'h55) good = 1'b0;
        if (k == 0 && cfg_sfd_chk)
          if (rx_ctrl[7] || rx_data[63:56] != 8'hD5) good = 1'b0;
        term = 1'b0;
        for (int b = 0; b < 8; b++)
          if (rx_ctrl[b] && rx_data[8*b +: 8] == 8'hFD) term = 1'b1;
        e_valid[k] <= 1'b0; e_sop[k] <= 1'b0; e_drop[k] <= 1'b0;
        e_data[k] <= rx_data; e_ctrl[k] <= rx_ctrl;
        if (m_mode[k] == 0) begin
          if (start && good) begin e_valid[k] <= 1'b1; e_sop[k] <= 1'b1; m_mode[k] = 1; end
          else if (start) begin e_drop[k] <= 1'b1; m_mode[k] = 2; end
        end else if (m_mode[k] == 1) begin
          e_valid[k] <= 1'b1;
          if (term) m_mode[k] = 0;
        end else if (term) m_mode[k] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < 2; k++) begin
        checks++;
        if (o_valid[k] !== e_valid[k] || o_sop[k] !== e_sop[k] || o_drop[k] !== e_drop[k] ||
            (e_valid[k] && (o_data[k] !== e_data[k] || o_ctrl[k] !== e_ctrl[k]))) begin
          errors++;
          $display("FAIL %s inst%0d t=%0t: got v=%b s=%b d=%b data=%h ctrl=%h, expected v=%b s=%b d=%b data=%h ctrl=%h",
                   cur_req, k, $time, o_valid[k], o_sop[k], o_drop[k], o_data[k], o_ctrl[k],
                   e_valid[k], e_sop[k], e_drop[k], e_data[k], e_ctrl[k]);
        end
      end
    end
  end

  task automatic put(input logic [DW-1:0] d, input logic [LANES-1:0] c);
    rx_data = d; rx_ctrl = c;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put({8{8'h07}}, 8'hFF);
  endtask

  task automatic term_word(input int lane);
    logic [DW-1:0] d; logic [LANES-1:0] c;
    for (int b = 0; b < 8; b++) begin
      if (b < lane) begin d[8*b +: 8] = 8'($urandom); c[b] = 1'b0; end
      else if (b == lane) begin d[8*b +: 8] = 8'hFD; c[b] = 1'b1; end
      else begin d[8*b +: 8] = 8'h07; c[b] = 1'b1; end
    end
    put(d, c);
  endtask

  // corrupt: 0 none, 1 preamble byte, 2 delimiter byte, 3 preamble flag, 4 both bytes
  task automatic packet(input int corrupt, input int body, input int tlane);
    logic [DW-1:0] d; logic [LANES-1:0] c;
    d = {8'hD5, {6{8'h55}}, 8'hFB}; c = 8'h01;
    if (corrupt == 1 || corrupt == 4) d[8*(1 + $urandom_range(0, 5)) +: 8] = 8'h54;
    if (corrupt == 2 || corrupt == 4) d[63:56] = 8'hD4;
    if (corrupt == 3) c[1 + $urandom_range(0, 5)] = 1'b1;
    put(d, c);
    for (int i = 0; i < body; i++) put({$urandom, $urandom}, 8'h00);
    term_word(tlane);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 2; k++) begin
      checks++;
      if (o_valid[k] !== 1'b0 || o_sop[k] !== 1'b0 || o_drop[k] !== 1'b0) begin
        errors++;
        $display("FAIL R1 inst%0d: got v=%b s=%b d=%b, expected 0 0 0", k, o_valid[k], o_sop[k], o_drop[k]);
      end
    end
    rst = 1'b0;
    cur_req = "R1"; idle(2);

    cur_req = "R2";
    put({{7{8'h55}}, 8'hFB}, 8'h00);           // start byte without control flag
    put({{7{8'h55}}, 8'hFC}, 8'h01);           // wrong control code in lane 0
    put({24'h555555, 8'hFB, 32'h07070707}, 8'h1F); // start byte in lane 4
    put({$urandom, $urandom}, 8'h00);
    term_word(2);
    idle(1);

    cur_req = "R3";
    for (int m = 0; m < 4; m++) begin
      cfg_pre_chk = m[1]; cfg_sfd_chk = m[0];
      packet(0, 2, m + 1); idle(1);
    end

    cur_req = "R4";
    for (int t = 0; t < 8; t++) begin packet(0, t % 3, t); idle(1); end

    cur_req = "R6";
    cfg_pre_chk = 1; cfg_sfd_chk = 0;
    packet(1, 2, 3); idle(1);
    packet(3, 1, 0); idle(1);
    packet(2, 1, 5); idle(1);   // damaged delimiter passes with only preamble check

    cur_req = "R7";
    cfg_pre_chk = 0; cfg_sfd_chk = 1;
    packet(2, 2, 7); idle(1);
    packet(1, 1, 4); idle(1);   // damaged preamble passes with only delimiter check

    cur_req = "R8";
    cfg_pre_chk = 1; cfg_sfd_chk = 1;
    packet(4, 4, 6); idle(1);
    packet(2, 0, 1); idle(1);

    cur_req = "R9";
    cfg_pre_chk = 0; cfg_sfd_chk = 0;
    rx_data = {8'hD5, {6{8'h55}}, 8'hFB}; rx_data[23:16] = 8'h00; rx_ctrl = 8'h01;
    @(negedge clk);
    cfg_pre_chk = 1; cfg_sfd_chk = 1;
    put({$urandom, $urandom}, 8'h00);
    term_word(3);
    cfg_pre_chk = 1; cfg_sfd_chk = 1;
    packet(1, 1, 2);             // dropped under bits held high
    cfg_pre_chk = 0; cfg_sfd_chk = 0;
    put({$urandom, $urandom}, 8'h00);
    term_word(0);
    idle(1);

    cur_req = "R10";
    packet(0, 1, 2); packet(0, 0, 4); packet(1, 1, 7); packet(0, 2, 1); idle(1);

    cur_req = "R5";
    for (int i = 0; i < 120; i++) begin
      cfg_pre_chk = 1'($urandom); cfg_sfd_chk = 1'($urandom);
      packet($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 7));
      idle($urandom_range(0, 2));
    end
    idle(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule